// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is a slave on a two-wire serial bus that behaves like a byte-addressed nonvolatile memory. SCL and SDA arrive as plain inputs sampled by the system clock. Both pass through a two-flop synchronizer before the block looks for edges. The block drives SDA only through an active-high pull-down enable, so the pin stays open-drain. The master opens each transaction with a START and a select byte. For writes it then sends a two-byte memory address and up to one page of data. For reads the block returns bytes from the current address, and the master asks for each further byte by acknowledging the previous one.

Write data first collects in a one-page buffer. The array changes only when a STOP ends a write that buffered at least one byte. That STOP starts a self-timed programming interval of a fixed number of clocks. During the interval the buffered bytes are committed and the block ignores the bus completely. A write-control input lets a board protect the array: the block still accepts the select and address bytes but refuses every data byte.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high. A START in any state except programming restarts the select-byte phase, including a repeated START inside a transaction. A STOP outside a write returns the block to idle.
- R2: Bytes are sampled on SCL rising edges, MSB first. The first byte after START is accepted only when bits 7..1 equal 1010000, and bit 0 = 1 selects read while bit 0 = 0 selects write. An accepted byte is acknowledged by pulling SDA low during the ninth clock. Any other value gets no acknowledge, and the block stays idle until the next START. Outside an acknowledge or a read data bit, SDA is released.
- R3: After a write select, the block takes the address high byte and then the low byte, acknowledging both. Only the low ADDR_W bits are used, so addresses that differ only above bit ADDR_W-1 select the same byte.
- R4: The block acknowledges each data byte after the address and buffers it at the current address. The low PAGE_W address bits then advance and wrap inside the page, so one write covers at most 2^PAGE_W bytes.
- R5: While wc_i is high, the select and address bytes are still acknowledged. Data bytes are not acknowledged and do not change the array.
- R6: A STOP that ends a write with at least one buffered byte starts a programming interval of PROG_CYCLES clocks, and the buffered bytes reach the array during it. A STOP after a write with no accepted data starts no interval, so the block answers the next START at once.
- R7: During the programming interval the block ignores START, STOP and all data, and it never pulls SDA low.
- R8: A random read is a write select, two address bytes, a repeated START and a read select. It returns the byte stored at that address.
- R9: During a read, each master acknowledge moves to the next address, wrapping from the last array byte to byte 0. A master no-acknowledge ends the read.
- R10: A read select with no address phase starts at the address that follows the last byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| wc_i | input | 1 | Write control, high blocks data bytes |
| sda_pd_o | output | 1 | SDA pull-down enable, high drives the line low |

## Verification
Fixed single-byte writes and reads show that addressing and acknowledge timing are right. A multi-byte write that starts near the end of a page shows whether the address wraps inside the page or runs on linearly. A read that runs past the last array byte tells the array wrap apart from the page wrap. Select bytes with a wrong code, a write attempt while wc_i is high, an address-only write, and a select sent during programming each target one refusal path. The random writes and sequential reads at random pages and lengths then check buffering and commit against a bench model of the array.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD, ST_PROG
  } st_e;
  localparam logic [6:0] DEV_CODE = 7'b1010000;
endpackage

// File: rtl/eeprom_i2c_front.sv
module eeprom_i2c_front (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  // [0],[1] synchronizer, [2] previous sample for edge detect
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  assign sda_o      = sda_q[1];
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] widx_i,
  input  logic [7:0]        wdata_i,
  input  logic [PAGE_W-1:0] ridx_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic              any_o
);
  localparam int PAGE = 1 << PAGE_W;

  logic [7:0]      data_q [PAGE];
  logic [PAGE-1:0] vld_q;

  always_ff @(posedge clk_i) begin
    if (we_i) data_q[widx_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= '0;
    else if (clr_i) vld_q <= '0;
    else if (we_i)  vld_q[widx_i] <= 1'b1;
  end

  assign rdata_o  = data_q[ridx_i];
  assign rvalid_o = vld_q[ridx_i];
  assign any_o    = |vld_q;
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_i2c_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 6,
  parameter int PROG_CYCLES = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wc_i,
  output logic sda_pd_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam int HI_W  = ADDR_W - 8;

  initial begin
    if (ADDR_W < 9 || ADDR_W > 16) $error("ADDR_W must be 9..16");
    if (PROG_CYCLES < PAGE) $error("PROG_CYCLES must cover one page");
  end

  logic scl_rise, scl_fall, start, stop, sda_s;

  eeprom_i2c_front i_front (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop), .sda_o(sda_s)
  );

  st_e               st_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        shreg_q;
  logic [HI_W-1:0]   ahi_q;
  logic [ADDR_W-1:0] addr_q;
  logic              mack_q, sda_pd_q;
  logic [CNT_W-1:0]  prog_cnt_q;
  logic [7:0]        mem_q [DEPTH];

  logic              byte_done, prog_last, buf_we, buf_clr, buf_vld, buf_any, mem_we;
  logic [7:0]        buf_rdata, mem_rdata;
  logic [PAGE_W-1:0] prog_idx;

  assign byte_done = scl_fall && bit_cnt_q == 4'd8;
  assign prog_last = st_q == ST_PROG && prog_cnt_q == CNT_W'(PROG_CYCLES - 1);
  assign buf_we    = st_q == ST_WR && byte_done && !wc_i;
  assign buf_clr   = prog_last || (start && st_q != ST_PROG);
  assign prog_idx  = prog_cnt_q[PAGE_W-1:0];

  eeprom_page_buf #(.PAGE_W(PAGE_W)) i_page_buf (
    .clk_i, .rst_ni,
    .clr_i(buf_clr), .we_i(buf_we),
    .widx_i(addr_q[PAGE_W-1:0]), .wdata_i(shreg_q),
    .ridx_i(prog_idx), .rdata_o(buf_rdata),
    .rvalid_o(buf_vld), .any_o(buf_any)
  );

  // commit one page slot per clock at the start of the interval
  assign mem_we    = st_q == ST_PROG && prog_cnt_q < CNT_W'(PAGE) && buf_vld;
  assign mem_rdata = mem_q[addr_q];

  always_ff @(posedge clk_i) begin
    if (mem_we) mem_q[{addr_q[ADDR_W-1:PAGE_W], prog_idx}] <= buf_rdata;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      ahi_q      <= '0;
      addr_q     <= '0;
      mack_q     <= 1'b0;
      sda_pd_q   <= 1'b0;
      prog_cnt_q <= '0;
    end else if (st_q == ST_PROG) begin
      if (prog_last) begin
        st_q       <= ST_IDLE;
        prog_cnt_q <= '0;
      end else begin
        prog_cnt_q <= prog_cnt_q + 1'b1;
      end
    end else if (start) begin
      st_q      <= ST_DEV;
      bit_cnt_q <= '0;
      sda_pd_q  <= 1'b0;
    end else if (stop) begin
      st_q      <= (st_q == ST_WR && buf_any) ? ST_PROG : ST_IDLE;
      bit_cnt_q <= '0;
      sda_pd_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
          if (scl_rise && bit_cnt_q < 4'd8) begin
            shreg_q   <= {shreg_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_rise && bit_cnt_q == 4'd8) begin
            bit_cnt_q <= 4'd9;
          end else if (byte_done) begin
            unique case (st_q)
              ST_DEV: if (shreg_q[7:1] == DEV_CODE) sda_pd_q <= 1'b1;
                      else st_q <= ST_IDLE;
              ST_AHI: begin
                ahi_q    <= shreg_q[HI_W-1:0];
                sda_pd_q <= 1'b1;
              end
              ST_ALO: begin
                addr_q   <= {ahi_q, shreg_q};
                sda_pd_q <= 1'b1;
              end
              default: if (!wc_i) begin
                sda_pd_q <= 1'b1;
                addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
              end
            endcase
          end else if (scl_fall && bit_cnt_q == 4'd9) begin
            bit_cnt_q <= '0;
            sda_pd_q  <= 1'b0;
            unique case (st_q)
              ST_DEV: if (shreg_q[0]) begin
                        st_q     <= ST_RD;
                        shreg_q  <= mem_rdata;
                        sda_pd_q <= ~mem_rdata[7];
                      end else st_q <= ST_AHI;
              ST_AHI:  st_q <= ST_ALO;
              ST_ALO:  st_q <= ST_WR;
              default: st_q <= ST_WR;
            endcase
          end
        end
        ST_RD: begin
          if (scl_rise && bit_cnt_q < 4'd9) begin
            if (bit_cnt_q == 4'd8) mack_q <= ~sda_s;
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt_q == 4'd8) begin
              sda_pd_q <= 1'b0;
              addr_q   <= addr_q + 1'b1;
            end else if (bit_cnt_q == 4'd9) begin
              bit_cnt_q <= '0;
              if (mack_q) begin
                shreg_q  <= mem_rdata;
                sda_pd_q <= ~mem_rdata[7];
              end else begin
                st_q <= ST_IDLE;
              end
            end else if (bit_cnt_q != 4'd0) begin
              shreg_q  <= {shreg_q[6:0], 1'b0};
              sda_pd_q <= ~shreg_q[6];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pd_o = sda_pd_q;
endmodule

// File: rtl/eeprom_i2c_chk.sv
module eeprom_i2c_chk
  import eeprom_i2c_pkg::*;
#(
  parameter int PROG_CYCLES = 400,
  parameter int CNT_W       = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wc_i,
  input logic             sda_pd_o,
  input st_e              st_i,
  input logic             start_i,
  input logic             stop_i,
  input logic [CNT_W-1:0] prog_cnt_i
);
  p_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_i != ST_PROG) |=> st_i == ST_DEV);

  p_stop_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && st_i inside {ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_RD}) |=> st_i == ST_IDLE);

  p_idle_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_IDLE |-> !sda_pd_o);

  p_data_nack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_pd_o) && st_i == ST_WR) |-> !$past(wc_i));

  p_prog_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_cnt_i < CNT_W'(PROG_CYCLES));

  p_prog_deaf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_PROG |-> !sda_pd_o);
endmodule

bind eeprom_i2c_slave eeprom_i2c_chk #(
  .PROG_CYCLES(PROG_CYCLES), .CNT_W(CNT_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wc_i(wc_i), .sda_pd_o(sda_pd_o),
  .st_i(st_q), .start_i(start), .stop_i(stop), .prog_cnt_i(prog_cnt_q)
);

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;
  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 11;
  localparam int PAGE_W      = 6;
  localparam int PROG_CYCLES = 400;
  localparam int DEPTH       = 1 << ADDR_W;
  localparam int PAGE        = 1 << PAGE_W;
  localparam int Q           = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wc = 1'b0;
  logic sda_pd;
  wire  sda_line = sda_m & ~sda_pd;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eeprom_i2c_slave #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES))
    i_eeprom_i2c_slave (.clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
                        .wc_i(wc), .sda_pd_o(sda_pd));

  int nvec = 0, nerr = 0, cur_ptr = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];
  logic [7:0] wbuf  [PAGE];

  function automatic int slot(int a, int i);
    return ((a & ~(PAGE - 1)) | ((a + i) & (PAGE - 1))) & (DEPTH - 1);
  endfunction
  function automatic int lin(int a, int i);
    return (a + i) & (DEPTH - 1);
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hp(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
    end
    sda_m = 1'b1; hp(); scl_m = 1'b1;
    repeat (Q / 2) @(negedge clk);
    ack = ~sda_line;
    repeat (Q / 2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_m = 1'b1;
      repeat (Q / 2) @(negedge clk);
      b[i] = sda_line;
      repeat (Q / 2) @(negedge clk);
      scl_m = 1'b0;
    end
    sda_m = ~ack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
  endtask

  task automatic addr_phase(input logic [15:0] a);
    logic ack;
    send_byte(8'hA0, ack); chk("R2", "write select ack", 16'(ack), 16'd1);
    send_byte(a[15:8], ack); chk("R3", "addr high ack", 16'(ack), 16'd1);
    send_byte(a[7:0], ack);  chk("R3", "addr low ack", 16'(ack), 16'd1);
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input bit exp_ack);
    logic ack;
    bus_start();
    addr_phase(a);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk(exp_ack ? "R4" : "R5", "data ack", 16'(ack), 16'(exp_ack));
    end
    bus_stop();
    if (exp_ack && n > 0) begin
      for (int i = 0; i < n; i++) model[slot(int'(a), i)] = wbuf[i];
      repeat (PROG_CYCLES + 20) @(negedge clk);
    end
  endtask

  task automatic read_body(input int a, input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(req, "read data", 16'(b), 16'(model[lin(a, i)]));
    end
    bus_stop();
    cur_ptr = lin(a, n);
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input string req);
    logic ack;
    bus_start();
    addr_phase(a);
    bus_start();
    send_byte(8'hA1, ack); chk("R1", "read select after restart", 16'(ack), 16'd1);
    read_body(int'(a) & (DEPTH - 1), n, req);
  endtask

  task automatic cur_read(input int n);
    logic ack;
    bus_start();
    send_byte(8'hA1, ack); chk("R10", "read select ack", 16'(ack), 16'd1);
    read_body(cur_ptr, n, "R10");
  endtask

  initial begin
    logic ack;
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2", "sda released after reset", 16'(sda_pd), 16'd0);

    // R2: wrong select codes refused, right one accepted
    bus_start(); send_byte(8'hA2, ack); chk("R2", "nonzero chip bits nack", 16'(ack), 16'd0); bus_stop();
    bus_start(); send_byte(8'hB0, ack); chk("R2", "wrong type nack", 16'(ack), 16'd0);
    send_byte(8'hA0, ack); chk("R2", "ignored until next START", 16'(ack), 16'd0); bus_stop();
    bus_start(); send_byte(8'hA0, ack); chk("R2", "select ack", 16'(ack), 16'd1); bus_stop();

    // R6/R7: byte write, bus ignored during programming
    bus_start(); addr_phase(16'h0010);
    send_byte(8'h5A, ack); chk("R4", "byte write ack", 16'(ack), 16'd1);
    bus_stop();
    repeat (10) @(negedge clk);
    bus_start(); send_byte(8'hA0, ack); chk("R7", "select during programming", 16'(ack), 16'd0);
    bus_stop();
    model[16'h0010] = 8'h5A;
    repeat (PROG_CYCLES) @(negedge clk);
    do_read(16'h0010, 1, "R6");

    // R6: address-only write starts no interval
    bus_start(); addr_phase(16'h0020); bus_stop();
    bus_start(); send_byte(8'hA0, ack); chk("R6", "no interval without data", 16'(ack), 16'd1); bus_stop();

    // R4: page wrap
    for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'hC0 + i);
    do_write(16'h013C, 8, 1'b1);
    do_read(16'h0100, 4, "R4");
    do_read(16'h013C, 4, "R4");

    // R3: upper address bits ignored
    wbuf[0] = 8'h3E;
    do_write(16'hF305, 1, 1'b1);
    do_read(16'h0305, 1, "R3");

    // R5: write control
    wc = 1'b1;
    wbuf[0] = 8'hFF; wbuf[1] = 8'h00;
    do_write(16'h0010, 2, 1'b0);
    wc = 1'b0;
    do_read(16'h0010, 1, "R5");

    // R9: read wraps at the array end; R10 current address
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    do_write(16'(DEPTH - 2), 2, 1'b1);
    wbuf[0] = 8'h33;
    do_write(16'h0000, 1, 1'b1);
    do_read(16'(DEPTH - 2), 3, "R9");
    for (int i = 0; i < 16; i++) wbuf[i] = 8'(i * 17 + 3);
    do_write(16'h0200, 16, 1'b1);
    do_read(16'h0200, 3, "R8");
    cur_read(4);

    // random pages and lengths
    for (int r = 0; r < 8; r++) begin
      int n, low, pg;
      n   = 1 + int'($urandom % 10);
      low = int'($urandom % (PAGE + 1 - n));
      pg  = int'($urandom % (DEPTH / PAGE));
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(16'(pg * PAGE + low), n, 1'b1);
      do_read(16'(pg * PAGE + low), n, "R8");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule